// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block turns interrupt input pins into outbound interrupt messages. Each pin has a two-word routing entry. The low word holds the vector, the delivery mode, the polarity, the trigger mode and a mask. The high word holds the destination, which is a processor ID in the upper byte and an extended ID in the lower byte. When a pin becomes active and is not masked, the block offers one message on a valid/ready port. The message carries the vector, the destination and the delivery mode of that pin.

Software reaches every internal register indirectly. It first writes an index into the select location, then reads or writes the selected 32-bit register through the data window. The select location is bus word 0 and the data window is bus word 1. Bus word 2 is the end-of-interrupt location: writing a vector there re-arms the level-triggered pins routed to that vector.

Top module: `irq_redirector`

## Requirements
- R1: The select location (bus word 0) holds a 16-bit register index that reads back unchanged. Bus word 1 reads and writes the register selected by that index, and bus reads of word 2 or 3 return zero.
- R2: Index 1 is a read-only version word: the version parameter in bits 7:0, NUM_PINS-1 in bits 23:16, and zero in all other bits.
- R3: After reset, every routing low word reads 0x0001_0000 (only the mask set), every high word reads zero, and no message is offered.
- R4: The low word of pin n sits at index 0x10+2n and the high word at 0x11+2n. The low-word fields are vector 7:0, delivery mode 10:8, polarity 13 (1 = active low), remote-IRR 14 (read-only), trigger 15 (1 = level) and mask 16. Other bits read zero, and a write to bit 14 is ignored. Rewriting the word with only the mask bit changed leaves every other field as it was. Indices not listed here read zero.
- R5: On an unmasked edge-triggered pin, each inactive-to-active transition produces exactly one message carrying that pin's vector, destination and mode. Holding the pin active produces no further messages.
- R6: An edge that occurs while its pin is masked is dropped. Unmasking afterwards produces no message, even if the input is still active.
- R7: With polarity set, a pin is active when its input is low.
- R8: A level-triggered pin sets remote-IRR (low word bit 14) when its message is accepted, and sends nothing more until that bit clears. An end-of-interrupt write whose vector does not match the pin's vector changes nothing. A matching write clears the bit.
- R9: If a level pin's input is still active when its remote-IRR is cleared, it sends again. A level pin that was active while masked sends as soon as it is unmasked.
- R10: Only one message is outstanding at a time. While msg_valid is high and msg_ready is low, vector, destination and mode hold steady. When several pins are pending, the lowest pin index is served first.
- R11: A new edge on a pin in the same cycle that pin's previous message is accepted is kept, and yields a second message.
- R12: The high word keeps the destination in bits 31:16 and reads zero in bits 15:0. Writing the high word leaves the low word unchanged. msg_dest carries bits 31:16 of the high word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Bus word: 0 select, 1 window, 2 end-of-interrupt |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational during a read strobe |
| irq_in | input | NUM_PINS | Interrupt input pins |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken when high together with msg_valid |
| msg_vector | output | 8 | Vector of the offered message |
| msg_dest | output | 16 | Destination (ID in 15:8, extended ID in 7:0) |
| msg_mode | output | 3 | Delivery mode (0 fixed, 1 lowest priority) |

## Verification
Two events on the same pin can land in one clock edge: the acceptance of that pin's outstanding message, and a fresh edge on its input. The bench provokes this by holding msg_ready low while a message waits, dropping the input, and then raising msg_ready and the input at the same time. It judges the result by demanding a second message for that pin. It also drives an end-of-interrupt write while a level input is still active, and requires a repeat message in that case and silence when the input has already dropped.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam int VEC_W  = 8;
  localparam int DEST_W = 16;
  localparam int MODE_W = 3;
  localparam int SEL_W  = 16;

  localparam logic [SEL_W-1:0] IDX_VERSION    = 16'h0001;
  localparam logic [SEL_W-1:0] IDX_ROUTE_BASE = 16'h0010;

  localparam logic [MODE_W-1:0] DM_FIXED  = 3'd0;
  localparam logic [MODE_W-1:0] DM_LOWEST = 3'd1;

  typedef struct packed {
    logic              mask;
    logic              trig;   // 1 = level
    logic              pol;    // 1 = active low
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vector;
    logic [DEST_W-1:0] dest;
  } route_t;

  localparam route_t ROUTE_RESET = '{mask: 1'b1, trig: 1'b0, pol: 1'b0,
                                     mode: '0, vector: '0, dest: '0};

  function automatic logic [31:0] pack_lo(input route_t r, input logic rirr);
    return {15'd0, r.mask, r.trig, rirr, r.pol, 2'b00, r.mode, r.vector};
  endfunction

  function automatic logic [31:0] pack_hi(input route_t r);
    return {r.dest, 16'd0};
  endfunction

  function automatic route_t unpack_lo(input route_t old, input logic [31:0] w);
    route_t nr;
    nr        = old;
    nr.vector = w[7:0];
    nr.mode   = w[10:8];
    nr.pol    = w[13];
    nr.trig   = w[15];
    nr.mask   = w[16];
    return nr;
  endfunction

  function automatic route_t unpack_hi(input route_t old, input logic [31:0] w);
    route_t nr;
    nr      = old;
    nr.dest = w[31:16];
    return nr;
  endfunction

  function automatic logic [31:0] version_word(input logic [7:0] ver,
                                               input logic [7:0] max_idx);
    return {8'd0, max_idx, 8'd0, ver};
  endfunction

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 4,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_req,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic [NUM_PINS-1:0]          rirr,
  output route_t [NUM_PINS-1:0]        routes,
  output logic                         eoi_valid,
  output logic [VEC_W-1:0]             eoi_vector
);

  localparam logic [SEL_W-1:0] ROUTE_END = IDX_ROUTE_BASE + SEL_W'(2 * NUM_PINS);
  localparam logic [7:0]       MAX_IDX   = 8'(NUM_PINS - 1);

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_off;
  logic             sel_is_route;
  logic             sel_wr, win_wr;
  logic [31:0]      win_rdata;

  assign sel_wr       = reg_req && reg_we && (reg_addr == 2'd0);
  assign win_wr       = reg_req && reg_we && (reg_addr == 2'd1);
  assign eoi_valid    = reg_req && reg_we && (reg_addr == 2'd2);
  assign eoi_vector   = reg_wdata[VEC_W-1:0];
  assign sel_off      = sel_q - IDX_ROUTE_BASE;
  assign sel_is_route = (sel_q >= IDX_ROUTE_BASE) && (sel_q < ROUTE_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= reg_wdata[SEL_W-1:0];
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_entry
    logic hit;
    assign hit = win_wr && sel_is_route && (sel_off[SEL_W-1:1] == (SEL_W-1)'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                routes[n] <= ROUTE_RESET;
      else if (hit && sel_off[0]) routes[n] <= unpack_hi(routes[n], reg_wdata);
      else if (hit)              routes[n] <= unpack_lo(routes[n], reg_wdata);
    end

    // R12: a high-word write leaves the low-word fields alone
    a_r12_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sel_off[0]) |=> ($stable(routes[n].vector) && $stable(routes[n].mode) &&
                              $stable(routes[n].pol) && $stable(routes[n].trig) &&
                              $stable(routes[n].mask)));
  end

  always_comb begin
    win_rdata = '0;
    if (sel_q == IDX_VERSION) win_rdata = version_word(VERSION, MAX_IDX);
    for (int n = 0; n < NUM_PINS; n++) begin
      if (sel_is_route && sel_off[SEL_W-1:1] == (SEL_W-1)'(n))
        win_rdata = sel_off[0] ? pack_hi(routes[n]) : pack_lo(routes[n], rirr[n]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_req && !reg_we) begin
      case (reg_addr)
        2'd0:    reg_rdata = 32'(sel_q);
        2'd1:    reg_rdata = win_rdata;
        default: reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_redir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             cfg_mask,
  input  logic             cfg_trig,
  input  logic             cfg_pol,
  input  logic [VEC_W-1:0] cfg_vector,
  input  logic             accept,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  output logic             req,
  output logic             rirr
);

  logic act, prev_act, edge_seen, edge_pend, eoi_hit;

  assign act       = pin_in ^ cfg_pol;
  assign edge_seen = act && !prev_act;
  assign eoi_hit   = eoi_valid && cfg_trig && (eoi_vector == cfg_vector);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_act <= 1'b0;
    else        prev_act <= act;
  end

  // edge memory: masked edges are discarded; a fresh edge outranks acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  edge_pend <= 1'b0;
    else if (cfg_mask || cfg_trig) edge_pend <= 1'b0;
    else if (edge_seen)          edge_pend <= 1'b1;
    else if (accept)             edge_pend <= 1'b0;
  end

  // remote IRR for level pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rirr <= 1'b0;
    else if (accept && cfg_trig) rirr <= 1'b1;
    else if (eoi_hit || !cfg_trig) rirr <= 1'b0;
  end

  assign req = cfg_trig ? (act && !cfg_mask && !rirr) : edge_pend;

  a_r6_masked_edge_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mask |=> !edge_pend);

  a_r8_rirr_set_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_trig) |=> rirr);

  a_r8_rirr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr && cfg_trig && !eoi_hit) |=> rirr);

  a_r8_rirr_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    rirr |-> !req);

  a_r11_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !cfg_mask && !cfg_trig) |=> edge_pend);

endmodule

// File: rtl/irq_issue.sv
module irq_issue
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_PINS-1:0]                req,
  input  logic [NUM_PINS-1:0][VEC_W-1:0]     vec_tab,
  input  logic [NUM_PINS-1:0][DEST_W-1:0]    dest_tab,
  input  logic [NUM_PINS-1:0][MODE_W-1:0]    mode_tab,
  input  logic                               msg_ready,
  output logic                               msg_valid,
  output logic [VEC_W-1:0]                   msg_vector,
  output logic [DEST_W-1:0]                  msg_dest,
  output logic [MODE_W-1:0]                  msg_mode,
  output logic [NUM_PINS-1:0]                accept
);

  logic [NUM_PINS-1:0] grant_oh, cur_oh;
  logic [VEC_W-1:0]    sel_vec;
  logic [DEST_W-1:0]   sel_dest;
  logic [MODE_W-1:0]   sel_mode;
  logic                load_now, handshake;

  always_comb begin
    grant_oh = '0;
    for (int n = NUM_PINS - 1; n >= 0; n--) begin
      if (req[n]) begin
        grant_oh    = '0;
        grant_oh[n] = 1'b1;
      end
    end
  end

  always_comb begin
    sel_vec  = '0;
    sel_dest = '0;
    sel_mode = '0;
    for (int n = 0; n < NUM_PINS; n++) begin
      if (grant_oh[n]) begin
        sel_vec  = sel_vec  | vec_tab[n];
        sel_dest = sel_dest | dest_tab[n];
        sel_mode = sel_mode | mode_tab[n];
      end
    end
  end

  assign handshake = msg_valid && msg_ready;
  assign load_now  = !msg_valid && (|req);
  assign accept    = handshake ? cur_oh : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      cur_oh     <= '0;
      msg_vector <= '0;
      msg_dest   <= '0;
      msg_mode   <= '0;
    end else if (handshake) begin
      msg_valid <= 1'b0;
    end else if (load_now) begin
      msg_valid  <= 1'b1;
      cur_oh     <= grant_oh;
      msg_vector <= sel_vec;
      msg_dest   <= sel_dest;
      msg_mode   <= sel_mode;
    end
  end

  a_r10_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
                                   $stable(msg_dest) && $stable(msg_mode)));

  a_r10_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(accept));

  a_r10_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |-> ((req & (grant_oh - NUM_PINS'(1))) == '0));

endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 4,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_req,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [15:0]         msg_dest,
  output logic [2:0]          msg_mode
);

  route_t [NUM_PINS-1:0]            routes;
  logic   [NUM_PINS-1:0]            rirr, req, accept;
  logic   [NUM_PINS-1:0][VEC_W-1:0]  vec_tab;
  logic   [NUM_PINS-1:0][DEST_W-1:0] dest_tab;
  logic   [NUM_PINS-1:0][MODE_W-1:0] mode_tab;
  logic                             eoi_valid;
  logic   [VEC_W-1:0]               eoi_vector;

  irq_regfile #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rirr(rirr), .routes(routes),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    assign vec_tab[n]  = routes[n].vector;
    assign dest_tab[n] = routes[n].dest;
    assign mode_tab[n] = routes[n].mode;

    irq_pin_ctrl u_pin (
      .clk(clk), .rst_n(rst_n),
      .pin_in(irq_in[n]),
      .cfg_mask(routes[n].mask), .cfg_trig(routes[n].trig),
      .cfg_pol(routes[n].pol), .cfg_vector(routes[n].vector),
      .accept(accept[n]),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .req(req[n]), .rirr(rirr[n])
    );
  end

  irq_issue #(.NUM_PINS(NUM_PINS)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .req(req), .vec_tab(vec_tab), .dest_tab(dest_tab), .mode_tab(mode_tab),
    .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_mode(msg_mode),
    .accept(accept)
  );

  // R3: nothing is offered in the first cycle out of reset
  a_r3_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !msg_valid);

endmodule

// File: tb/test_irq_redirector.sv
module test_irq_redirector;

  localparam int         N   = 4;
  localparam logic [7:0] VER = 8'h21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] irq_in = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_vector;
  logic [15:0] msg_dest;
  logic [2:0]  msg_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_redirector #(.NUM_PINS(N), .VERSION(VER)) i_irq_redirector (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_mode(msg_mode));

  function automatic logic [7:0]  vec_of(int n);  return 8'h30 + 8'(n * 7); endfunction
  function automatic logic [15:0] dest_of(int n); return {8'(n + 1), 8'(8'hA0 + n)}; endfunction
  function automatic logic [2:0]  mode_of(int n); return 3'(n % 2); endfunction
  function automatic logic [15:0] lo_idx(int n);  return 16'(16 + 2 * n); endfunction
  function automatic logic [31:0] lo_word(logic [7:0] v, logic [2:0] m, logic p,
                                          logic t, logic k, logic r);
    return {15'd0, k, t, r, p, 2'b00, m, v};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_req = 1'b0;
  endtask

  task automatic reg_write(input logic [15:0] idx, input logic [31:0] d);
    bus_wr(2'd0, 32'(idx));
    bus_wr(2'd1, d);
  endtask

  task automatic reg_read(input logic [15:0] idx, output logic [31:0] d);
    bus_wr(2'd0, 32'(idx));
    bus_rd(2'd1, d);
  endtask

  task automatic take_msg(input logic [7:0] v, input logic [15:0] d,
                          input logic [2:0] m, input string tag);
    int w = 0;
    @(negedge clk);
    while (!msg_valid && w < 20) begin @(negedge clk); w++; end
    check(32'(msg_valid), 32'd1, {tag, " valid"});
    check(32'({msg_mode, msg_vector, msg_dest}), 32'({m, v, d}), {tag, " payload"});
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic expect_quiet(input int cycles, input string tag);
    int seen = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (msg_valid) seen++;
    end
    check(32'(seen), 32'd0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  v3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    #1 check(32'(msg_valid), 0, "R3 no message after reset");
    for (int n = 0; n < N; n++) begin
      reg_read(lo_idx(n), rd);       check(rd, 32'h0001_0000, "R3 low word reset");
      reg_read(lo_idx(n) + 1, rd);   check(rd, 32'h0, "R3 high word reset");
    end

    // R2 version, R1 select readback, R4 unimplemented indices
    reg_read(16'h0001, rd);
    check(rd, {8'd0, 8'(N - 1), 8'd0, VER}, "R2 version word");
    bus_wr(2'd0, 32'h0000_5A5B);
    bus_rd(2'd0, rd);  check(rd, 32'h0000_5A5B, "R1 select readback");
    bus_rd(2'd1, rd);  check(rd, 32'h0, "R4 unimplemented index reads zero");
    bus_rd(2'd2, rd);  check(rd, 32'h0, "R1 word 2 reads zero");
    reg_read(16'(16 + 2 * N), rd); check(rd, 32'h0, "R4 index past last entry");
    reg_read(16'h0000, rd); check(rd, 32'h0, "R4 index 0 reads zero");

    // program all pins as edge, unmasked; R4 reserved/RO bits, R12 high word
    for (int n = 0; n < N; n++) begin
      reg_write(lo_idx(n) + 1, {dest_of(n), 16'hFFFF});
      reg_read(lo_idx(n) + 1, rd);
      check(rd, {dest_of(n), 16'h0}, "R12 high word keeps bits 31:16 only");
      reg_write(lo_idx(n), lo_word(vec_of(n), mode_of(n), 0, 0, 1, 0) | 32'hFFFE_5800);
      reg_read(lo_idx(n), rd);
      check(rd, lo_word(vec_of(n), mode_of(n), 0, 0, 1, 0), "R4 field layout, bit 14 ignored");
      reg_write(lo_idx(n), lo_word(vec_of(n), mode_of(n), 0, 0, 0, 0));
      reg_read(lo_idx(n), rd);
      check(rd, lo_word(vec_of(n), mode_of(n), 0, 0, 0, 0), "R4 mask cleared, rest kept");
      reg_read(lo_idx(n) + 1, rd);
      check(rd, {dest_of(n), 16'h0}, "R12 low write keeps high word");
    end

    // R5 single message per edge for each pin
    for (int n = 0; n < N; n++) begin
      @(negedge clk); irq_in[n] = 1'b1;
      take_msg(vec_of(n), dest_of(n), mode_of(n), "R5 edge message");
      expect_quiet(8, "R5 held pin sends once");
      @(negedge clk); irq_in[n] = 1'b0;
      expect_quiet(4, "R5 release sends nothing");
    end

    // R7 active-low polarity on pin 2, with the change made while masked (R6)
    reg_write(lo_idx(2), lo_word(vec_of(2), mode_of(2), 1, 0, 1, 0));
    @(negedge clk); irq_in[2] = 1'b1;
    reg_write(lo_idx(2), lo_word(vec_of(2), mode_of(2), 1, 0, 0, 0));
    expect_quiet(4, "R7 high input inactive when active low");
    @(negedge clk); irq_in[2] = 1'b0;
    take_msg(vec_of(2), dest_of(2), mode_of(2), "R7 falling edge sends");
    @(negedge clk); irq_in[2] = 1'b1;
    expect_quiet(6, "R7 rising edge silent");
    reg_write(lo_idx(2), lo_word(vec_of(2), mode_of(2), 1, 0, 1, 0));
    @(negedge clk); irq_in[2] = 1'b0;
    reg_write(lo_idx(2), lo_word(vec_of(2), mode_of(2), 0, 0, 0, 0));
    expect_quiet(6, "R6 polarity restore under mask silent");

    // R6 masked edge dropped
    reg_write(lo_idx(1), lo_word(vec_of(1), mode_of(1), 0, 0, 1, 0));
    @(negedge clk); irq_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    irq_in[1] = 1'b0;
    reg_write(lo_idx(1), lo_word(vec_of(1), mode_of(1), 0, 0, 0, 0));
    expect_quiet(8, "R6 edge during mask dropped");
    reg_write(lo_idx(1), lo_word(vec_of(1), mode_of(1), 0, 0, 1, 0));
    @(negedge clk); irq_in[1] = 1'b1;
    reg_write(lo_idx(1), lo_word(vec_of(1), mode_of(1), 0, 0, 0, 0));
    expect_quiet(8, "R6 unmask with input still high silent");
    @(negedge clk); irq_in[1] = 1'b0;

    // R10 priority and hold-steady
    @(negedge clk); irq_in = '1;
    repeat (5) @(negedge clk);
    check(32'({msg_valid, msg_vector}), 32'({1'b1, vec_of(0)}), "R10 held message steady");
    for (int n = 0; n < N; n++)
      take_msg(vec_of(n), dest_of(n), mode_of(n), "R10 lowest pin first");
    expect_quiet(6, "R10 each pin once");
    @(negedge clk); irq_in = '0;

    // R11 new edge in the acceptance cycle
    @(negedge clk); irq_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    irq_in[0] = 1'b0;
    @(negedge clk);
    check(32'({msg_valid, msg_vector}), 32'({1'b1, vec_of(0)}), "R11 first message waiting");
    msg_ready = 1'b1; irq_in[0] = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    take_msg(vec_of(0), dest_of(0), mode_of(0), "R11 second message kept");
    expect_quiet(6, "R11 no third message");
    @(negedge clk); irq_in[0] = 1'b0;

    // R8 / R9 level pin 3
    v3 = vec_of(3);
    reg_write(lo_idx(3), lo_word(v3, mode_of(3), 0, 1, 0, 0));
    @(negedge clk); irq_in[3] = 1'b1;
    take_msg(v3, dest_of(3), mode_of(3), "R8 level message");
    reg_read(lo_idx(3), rd);
    check(rd, lo_word(v3, mode_of(3), 0, 1, 0, 1), "R8 remote-IRR set");
    expect_quiet(8, "R8 blocked until EOI");
    bus_wr(2'd2, 32'(v3 + 8'd1));
    expect_quiet(6, "R8 mismatched EOI ignored");
    reg_read(lo_idx(3), rd);
    check(rd, lo_word(v3, mode_of(3), 0, 1, 0, 1), "R8 remote-IRR kept on mismatch");
    bus_wr(2'd2, 32'(v3));
    take_msg(v3, dest_of(3), mode_of(3), "R9 still active after EOI resends");
    @(negedge clk); irq_in[3] = 1'b0;
    bus_wr(2'd2, 32'(v3));
    reg_read(lo_idx(3), rd);
    check(rd, lo_word(v3, mode_of(3), 0, 1, 0, 0), "R8 EOI clears remote-IRR");
    expect_quiet(6, "R8 inactive level silent");
    reg_write(lo_idx(3), lo_word(v3, mode_of(3), 0, 1, 1, 0));
    @(negedge clk); irq_in[3] = 1'b1;
    expect_quiet(6, "R9 masked level silent");
    reg_write(lo_idx(3), lo_word(v3, mode_of(3), 0, 1, 0, 0));
    take_msg(v3, dest_of(3), mode_of(3), "R9 unmasked level sends");
    @(negedge clk); irq_in[3] = 1'b0;
    bus_wr(2'd2, 32'(v3));
    expect_quiet(4, "R8 final idle");

    finish_run();
  end

endmodule